// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block models the device side of a DDR SDRAM read data path. When a read command is accepted, it waits the programmed CAS latency. It then drives the burst as one pair of data words per clock: an even word for the rising half and an odd word for the falling half. Alongside each pair it drives an output-enable and the strobe levels for both halves. This pair form keeps all logic on a single clock edge while still carrying two words per cycle.

A precharge to the bank being read can cut the burst short. The pair due CAS-latency cycles after that precharge is the last one driven. On the following cycle the output-enable drops, which stands for the bus going to high impedance. A precharge issued late enough leaves the burst whole. A precharge to any other bank is ignored.

The word source is a start value captured with the read. Word i of the burst is that value plus i. The CAS latency and the burst-length code are inputs that are held steady while traffic runs.

Top module: `ddr_rd_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `dq_oe` is 0, both data words are 0 and `dqs_lvl` is 0. A read command presented during reset starts nothing.
- R2: A read accepted at clock edge 0 puts its first pair on the outputs just after edge `cas_lat` (1 to CL_MAX). The even word of that pair equals `rd_seed`.
- R3: Pair i of a burst carries even word `rd_seed + 2i` and odd word `rd_seed + 2i + 1`, modulo 2^DATA_W. Pairs follow on consecutive cycles.
- R4: `bl_code` value c (0, 1 or 2) gives a burst of 2^(c+1) words, that is 2^c pairs. Any larger code is treated as 2.
- R5: A precharge to the reading bank at edge k after the read (k ≥ 1) makes the pair at edge k + `cas_lat` the last one driven. The burst then has min(k+1, 2^c) pairs.
- R6: A precharge to the reading bank at edge k ≥ 2^c − 1 after the read leaves the whole burst delivered.
- R7: `dq_oe` is high exactly on the cycles that carry a pair. It falls on the cycle after the last pair and stays low until the next burst.
- R8: While `dq_oe` is high, `dqs_lvl` is 2'b01: bit 0 is high for the rising half and bit 1 is low for the falling half. Otherwise `dqs_lvl` and both data words are 0.
- R9: A precharge whose bank differs from the reading bank has no effect on the burst.
- R10: A read command arriving while a burst is pending or being driven is ignored.
- R11: `cmd_op` encoding: 2'b00 no operation, 2'b01 read, 2'b10 precharge, 2'b11 treated as no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command code (see R11) |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| rd_seed | input | DATA_W | First word of the burst, captured with the read |
| cas_lat | input | CL_W | CAS latency in cycles, 1 to CL_MAX |
| bl_code | input | BLC_W | Burst length code, burst = 2^(code+1) words |
| dq_even | output | DATA_W | Word driven in the rising half of the cycle |
| dq_odd | output | DATA_W | Word driven in the falling half of the cycle |
| dq_oe | output | 1 | Output enable; low means the bus is tristated |
| dqs_lvl | output | 2 | Strobe level for rising half (bit 0) and falling half (bit 1) |

## Verification
A read accepted at edge 0 produces pair i at edge `cas_lat` + i. A precharge at edge k ends the burst with the pair at edge k + `cas_lat`, and the output-enable is low after the following edge. The bench applies each command before edge j and samples on the falling edge after edge j. For every sampled cycle it computes, from these offsets, the expected enable, words and strobe, and it counts the words driven per burst. This count is then compared with min(k+1, pairs) × 2, or with the full burst when the precharge is absent or targets another bank.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_PRE   = 2'b10,
        OP_OTHER = 2'b11
    } op_e;

    localparam logic [1:0] STROBE_ACTIVE = 2'b01;
    localparam logic [1:0] STROBE_IDLE   = 2'b00;

endpackage

// File: rtl/ddr_rd_cdown.sv
// Single-shot countdown: load arms it, fire is high for one cycle when it expires.
module ddr_rd_cdown #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire,
    output logic             busy
);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } cd_t;

    cd_t cd_q, cd_d;

    assign fire = cd_q.pend && (cd_q.cnt == '0);
    assign busy = cd_q.pend;

    always_comb begin
        cd_d = cd_q;
        if (clear) begin
            cd_d.pend = 1'b0;
        end else if (load) begin
            cd_d.pend = 1'b1;
            cd_d.cnt  = load_val;
        end else if (fire) begin
            cd_d.pend = 1'b0;
        end else if (cd_q.pend) begin
            cd_d.cnt = cd_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

endmodule

// File: rtl/ddr_rd_wordgen.sv
// Computes the even/odd word pair for a given pair index.
module ddr_rd_wordgen #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] seed,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] even_w,
    output logic [DATA_W-1:0] odd_w
);

    logic [IDX_W:0] word_off;

    assign word_off = {idx, 1'b0};
    assign even_w   = seed + DATA_W'(word_off);
    assign odd_w    = even_w + 1'b1;

endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
    import ddr_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int BANK_W      = 2,
    parameter int CL_MAX      = 5,
    parameter int BL_CODE_MAX = 2,
    localparam int CL_W       = $clog2(CL_MAX + 1),
    localparam int BLC_W      = (BL_CODE_MAX < 1) ? 1 : $clog2(BL_CODE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [DATA_W-1:0] rd_seed,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic [BLC_W-1:0]  bl_code,
    output logic [DATA_W-1:0] dq_even,
    output logic [DATA_W-1:0] dq_odd,
    output logic              dq_oe,
    output logic [1:0]        dqs_lvl
);

    localparam int PAIR_W = BL_CODE_MAX + 1;

    typedef struct packed {
        logic              run;
        logic [PAIR_W-1:0] beat;
        logic [PAIR_W-1:0] nbeat;
        logic [BANK_W-1:0] bank;
        logic [DATA_W-1:0] seed;
        logic              oe;
        logic [DATA_W-1:0] even;
        logic [DATA_W-1:0] odd;
        logic [1:0]        dqs;
    } seq_t;

    seq_t seq_q, seq_d;

    op_e               op;
    logic              busy, rd_ok, pre_hit;
    logic              lat_fire, lat_busy, cut_fire, cut_busy;
    logic              emit, last_pair;
    logic [CL_W-1:0]   cl_m1;
    logic [BLC_W-1:0]  code_eff;
    logic [PAIR_W-1:0] idx, idx_inc;
    logic [DATA_W-1:0] w_even, w_odd;

    assign op       = op_e'(cmd_op);
    assign busy     = lat_busy || seq_q.run;
    assign rd_ok    = (op == OP_READ) && !busy;
    assign pre_hit  = (op == OP_PRE) && busy && (cmd_bank == seq_q.bank);
    assign cl_m1    = (cas_lat == '0) ? '0 : cas_lat - 1'b1;
    assign code_eff = (bl_code > BLC_W'(BL_CODE_MAX)) ? BLC_W'(BL_CODE_MAX) : bl_code;

    // A pair is driven on the edge the latency expires or while a burst runs.
    assign emit      = lat_fire || seq_q.run;
    assign idx       = lat_fire ? '0 : seq_q.beat;
    assign idx_inc   = idx + 1'b1;
    assign last_pair = emit && !seq_d.run;

    ddr_rd_cdown #(.CNT_W(CL_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_ok),
        .clear    (1'b0),
        .load_val (cl_m1),
        .fire     (lat_fire),
        .busy     (lat_busy)
    );

    ddr_rd_cdown #(.CNT_W(CL_W)) u_cut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pre_hit && !cut_busy),
        .clear    (last_pair),
        .load_val (cl_m1),
        .fire     (cut_fire),
        .busy     (cut_busy)
    );

    ddr_rd_wordgen #(.DATA_W(DATA_W), .IDX_W(PAIR_W)) u_words (
        .seed   (seq_q.seed),
        .idx    (idx),
        .even_w (w_even),
        .odd_w  (w_odd)
    );

    always_comb begin
        seq_d = seq_q;
        if (rd_ok) begin
            seq_d.bank  = cmd_bank;
            seq_d.seed  = rd_seed;
            seq_d.nbeat = PAIR_W'(1) << code_eff;
        end
        seq_d.oe   = emit;
        seq_d.even = emit ? w_even : '0;
        seq_d.odd  = emit ? w_odd  : '0;
        seq_d.dqs  = emit ? STROBE_ACTIVE : STROBE_IDLE;
        if (emit) begin
            seq_d.beat = idx_inc;
            seq_d.run  = !cut_fire && (idx_inc < seq_q.nbeat);
        end else begin
            seq_d.run  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign dq_even = seq_q.even;
    assign dq_odd  = seq_q.odd;
    assign dq_oe   = seq_q.oe;
    assign dqs_lvl = seq_q.dqs;

endmodule

// File: rtl/ddr_rd_seq_chk.sv
module ddr_rd_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_even,
    input logic [DATA_W-1:0] dq_odd,
    input logic [1:0]        dqs_lvl
);

    // R8
    active_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dqs_lvl == 2'b01));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dqs_lvl == 2'b00 && dq_even == '0 && dq_odd == '0));

    // R3
    odd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dq_odd == DATA_W'(dq_even + 1'b1)));

    // R3
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> (dq_even == DATA_W'($past(dq_even) + 2'd2)));

endmodule

bind ddr_rd_seq ddr_rd_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dq_oe   (dq_oe),
    .dq_even (dq_even),
    .dq_odd  (dq_odd),
    .dqs_lvl (dqs_lvl)
);

// File: tb/ddr_rd_seq_tb.sv
module ddr_rd_seq_tb;

    localparam int DATA_W = 16;
    localparam int BANK_W = 2;
    localparam int CL_MAX = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [DATA_W-1:0] rd_seed = '0;
    logic [2:0]        cas_lat = 3'd3;
    logic [1:0]        bl_code = 2'd2;
    logic [DATA_W-1:0] dq_even, dq_odd;
    logic              dq_oe;
    logic [1:0]        dqs_lvl;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ddr_rd_seq #(.DATA_W(DATA_W), .BANK_W(BANK_W), .CL_MAX(CL_MAX), .BL_CODE_MAX(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .rd_seed(rd_seed), .cas_lat(cas_lat), .bl_code(bl_code),
        .dq_even(dq_even), .dq_odd(dq_odd), .dq_oe(dq_oe), .dqs_lvl(dqs_lvl)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_pairs(input int code, input int pre_k, input bit other);
        int nb = 1 << code;
        if (pre_k < 0 || other) return nb;
        return (pre_k + 1 < nb) ? pre_k + 1 : nb;
    endfunction

    // READ at edge 0; optional precharge at edge pre_k; optional second READ at edge rd2_k.
    task automatic run_case(input int cl, input int code, input logic [DATA_W-1:0] seed,
                            input int pre_k, input bit other, input int rd2_k);
        int nb = 1 << code;
        int n = exp_pairs(code, pre_k, other);
        logic [BANK_W-1:0] bk = BANK_W'($urandom % 4);
        int words = 0;
        bit trace_ok = 1'b1;
        int bad_act = 0;
        int bad_exp = 0;
        string tag;
        if (rd2_k >= 0)                            tag = "R10";
        else if (pre_k >= 0 && other)              tag = "R9";
        else if (pre_k >= 0 && pre_k >= nb - 1)    tag = "R6";
        else if (pre_k >= 0)                       tag = "R5";
        else                                       tag = "R4";
        cas_lat = 3'(cl);
        bl_code = 2'(code);
        for (int j = 0; j < cl + nb + 3; j++) begin
            cmd_op = 2'b00;
            if (j == 0) begin
                cmd_op = 2'b01; cmd_bank = bk; rd_seed = seed;
            end else if (j == pre_k) begin
                cmd_op = 2'b10; cmd_bank = other ? bk ^ 2'b01 : bk;
            end else if (j == rd2_k) begin
                cmd_op = 2'b01; cmd_bank = bk; rd_seed = seed ^ 16'h5555;
            end
            @(posedge clk);
            @(negedge clk);
            begin
                bit e_oe = (j >= cl) && (j < cl + n);
                logic [DATA_W-1:0] e_ev = e_oe ? DATA_W'(seed + 2 * (j - cl)) : '0;
                logic [DATA_W-1:0] e_od = e_oe ? DATA_W'(e_ev + 1) : '0;
                logic [1:0] e_dqs = e_oe ? 2'b01 : 2'b00;
                if (dq_oe) words += 2;
                if (trace_ok && (dq_oe !== e_oe || dq_even !== e_ev ||
                                 dq_odd !== e_od || dqs_lvl !== e_dqs)) begin
                    trace_ok = 1'b0;
                    bad_act = int'(dq_even);
                    bad_exp = int'(e_ev);
                    $display("  cycle %0d: oe %0b/%0b dqs %0d/%0d", j, dq_oe, e_oe, dqs_lvl, e_dqs);
                end
            end
        end
        cmd_op = 2'b00;
        // R2 R3 R7 R8: per-cycle enable, words and strobe
        chk(trace_ok, "R2/R3/R7/R8", "trace even word", bad_act, bad_exp);
        chk(words == 2 * n, tag, "word count", words, 2 * n);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset holds outputs idle, even with a READ presented
        cmd_op = 2'b01; rd_seed = 16'h1234;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(dq_oe == 1'b0 && dq_even == '0 && dqs_lvl == 2'b00, "R1", "idle in reset", int'(dq_oe), 0);
        cmd_op = 2'b00;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(dq_oe == 1'b0 && dq_odd == '0, "R1", "idle after reset", int'(dq_oe), 0);

        // Directed corner cases, CL=3, BL=8 (R11 encodings used throughout)
        run_case(3, 2, 16'h0100, -1, 1'b0, -1);   // R4 full burst
        run_case(3, 2, 16'h0200, 1, 1'b0, -1);    // R5 minimum spacing: 2 pairs
        run_case(3, 2, 16'h0300, 2, 1'b0, -1);    // R5: 3 pairs
        run_case(3, 2, 16'h0400, 3, 1'b0, -1);    // R6 earliest non-cutting precharge
        run_case(3, 2, 16'h0500, 5, 1'b0, -1);    // R6 late precharge
        run_case(3, 2, 16'h0600, 1, 1'b1, -1);    // R9 other bank
        run_case(3, 2, 16'h0700, -1, 1'b0, 2);    // R10 second read ignored
        run_case(1, 1, 16'h0800, 1, 1'b0, -1);    // R2 CL=1
        run_case(5, 0, 16'h0900, -1, 1'b0, -1);   // R4 shortest burst, longest CL
        run_case(2, 2, 16'hFFFC, -1, 1'b0, -1);   // R3 word wrap

        // Constrained random mix
        for (int i = 0; i < 60; i++) begin
            int cl   = 1 + int'($urandom % CL_MAX);
            int code = int'($urandom % 3);
            int sel  = int'($urandom % 4);
            int pk   = 1 + int'($urandom % ((1 << code) + 2));
            logic [DATA_W-1:0] sd = DATA_W'($urandom);
            case (sel)
                0:       run_case(cl, code, sd, -1, 1'b0, -1);
                1:       run_case(cl, code, sd, pk, 1'b1, -1);
                default: run_case(cl, code, sd, pk, 1'b0, -1);
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule